// File: doc/BRIEF.md
# Single-Precision Subtract Unit with Exception Trapping

This block computes `Rn - Rm` for two single-precision operands and decides whether the destination register may be written. Each operand is sorted into one of six classes: zero, normal, infinity, quiet NaN, signaling NaN or denormal. A fixed precedence then settles every special combination. Two normal operands go through a true subtract path with exponent alignment and round-to-nearest-even. Results that overflow become a signed infinity. Results below the smallest normal become a signed zero.

An operation starts with a one-cycle `start` pulse. One cycle later `done` pulses together with `wr_en` and `trap_req`, and `result` and `cause` are updated. `cause` holds only the exceptions of the latest operation. `flags` collects them until `flag_clr` is raised. Any denormal input is refused with an unimplemented-operation cause and a trap. Any of the overflow, underflow or inexact trap enables forces a trap on every operation. A trap always blocks the destination write. The surrounding decoder issues this operation for the 16-bit instruction pattern `1111nnnnmmmm0001`, with `n` naming the minuend and destination and `m` the subtrahend.

Top module: `fp_sub_unit`

## Requirements
- R1: A NaN is signaling when fraction bit 22 is 1 and quiet when it is 0. If either operand is signaling NaN, the invalid cause is raised and the result is the default quiet NaN 0x7FBFFFFF. This test takes precedence over every other case, including denormals.
- R2: If neither operand is signaling NaN but one is a quiet NaN, the result is 0x7FBFFFFF with no cause bit set, even when the other operand is denormal.
- R3: If no NaN is present and either operand is denormal (exponent 0, fraction non-zero), the unimplemented cause is raised, `trap_req` pulses, `wr_en` stays low and `result` shows Rn unchanged.
- R4: For two normal operands the result is Rn - Rm rounded to nearest-even, with inexact set when rounding dropped bits. Exact cancellation gives +0.
- R5: A rounded exponent above the largest finite value gives a correctly signed infinity with overflow and inexact set. A result below the smallest normal gives a correctly signed zero with underflow and inexact set.
- R6: Infinity minus an infinity of the same sign raises invalid and gives 0x7FBFFFFF. Otherwise an infinite Rn is returned as is, and an infinite Rm (with finite Rn) is returned with its sign flipped.
- R7: If Rm is normal and Rn is zero, the result is Rm negated. If Rm is zero and Rn is normal, the result is Rn. With both zero, the result is -0 only for (-0) - (+0), and +0 otherwise.
- R8: `cause` is five bits `{unimplemented, invalid, overflow, underflow, inexact}` (bit 4 down to 0). Each operation replaces it, so no bit carries over from an earlier operation. It is 0 after reset.
- R9: `flags` is four bits `{invalid, overflow, underflow, inexact}`. Each operation ORs its cause bits into `flags`. A bit is never lost except through `flag_clr`, which empties `flags` on the next edge.
- R10: `trap_en` is `{invalid, overflow, underflow, inexact}` (bit 3 down to 0). Any of bits 2..0 set forces `trap_req` on that operation even when no such exception occurred. Bit 3 traps only when invalid is raised. Every trap blocks `wr_en`.
- R11: `done` pulses exactly one cycle after each `start`, with `wr_en` equal to not-trap. Without `start`, `done`, `wr_en` and `trap_req` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation on the present operands |
| src_n | input | 32 | Minuend Rn |
| src_m | input | 32 | Subtrahend Rm |
| trap_en | input | 4 | Trap enables {invalid, overflow, underflow, inexact} |
| flag_clr | input | 1 | Clear the sticky flags |
| done | output | 1 | Result valid pulse, one cycle after start |
| result | output | 32 | Difference or special value |
| wr_en | output | 1 | Destination may be written |
| cause | output | 5 | Exceptions of the latest operation |
| flags | output | 4 | Sticky exception record |
| trap_req | output | 1 | Trap request pulse |

## Verification
The bench builds the unit with its default widths of 8 exponent and 23 fraction bits. With these widths the default NaN 0x7FBFFFFF, the largest finite value, the smallest normal and the 2^-24 half-way points next to 1.0 can all be written as exact hand-derived constants. With them the bench reaches rounding ties in both directions, both overflow signs, underflow flushing to either signed zero, and every step of the NaN, denormal and infinity precedence.

// File: rtl/fsub_pkg.sv
package fsub_pkg;

    localparam int EXP_W_DEF  = 8;
    localparam int FRAC_W_DEF = 23;

    typedef enum logic [2:0] {
        CL_ZERO,
        CL_NORM,
        CL_INF,
        CL_QNAN,
        CL_SNAN,
        CL_DENORM
    } opclass_e;

    typedef struct packed {
        logic unimpl;
        logic invalid;
        logic ovf;
        logic unf;
        logic inx;
    } exc_t;

    typedef struct packed {
        logic invalid;
        logic ovf;
        logic unf;
        logic inx;
    } trapen_t;

    localparam int EXC_W  = $bits(exc_t);
    localparam int FLAG_W = $bits(trapen_t);

    function automatic logic [FLAG_W-1:0] exc_to_flag(input exc_t e);
        return {e.invalid, e.ovf, e.unf, e.inx};
    endfunction

endpackage

// File: rtl/fsub_classify.sv
module fsub_classify
    import fsub_pkg::*;
#(
    parameter int EXP_W  = EXP_W_DEF,
    parameter int FRAC_W = FRAC_W_DEF,
    localparam int W     = 1 + EXP_W + FRAC_W
) (
    input  logic [W-1:0] val,
    output opclass_e     cls
);
    logic [EXP_W-1:0]  ex;
    logic [FRAC_W-1:0] fr;

    assign ex = val[W-2 -: EXP_W];
    assign fr = val[FRAC_W-1:0];

    always_comb begin
        if (ex == '0)
            cls = (fr == '0) ? CL_ZERO : CL_DENORM;
        else if (&ex) begin
            if (fr == '0)          cls = CL_INF;
            else if (fr[FRAC_W-1]) cls = CL_SNAN;
            else                   cls = CL_QNAN;
        end else
            cls = CL_NORM;
    end
endmodule

// File: rtl/fsub_core.sv
module fsub_core
    import fsub_pkg::*;
#(
    parameter int EXP_W  = EXP_W_DEF,
    parameter int FRAC_W = FRAC_W_DEF,
    localparam int W     = 1 + EXP_W + FRAC_W,
    localparam int MW    = FRAC_W + 4,
    localparam int LZW   = $clog2(MW + 1),
    localparam int EW    = EXP_W + 2
) (
    input  logic [W-1:0] op_n,
    input  logic [W-1:0] op_m,
    output logic [W-1:0] res,
    output exc_t         exc
);
    localparam logic signed [EW-1:0] E_TOP = EW'((1 << EXP_W) - 1);

    function automatic logic [LZW-1:0] lead_zeros(input logic [MW-1:0] v);
        logic [LZW-1:0] c;
        logic hit;
        c   = '0;
        hit = 1'b0;
        for (int i = MW - 1; i >= 0; i--) begin
            if (!hit) begin
                if (v[i]) hit = 1'b1;
                else      c   = c + 1'b1;
            end
        end
        return c;
    endfunction

    logic                  sa, sb, swap;
    logic [EXP_W-1:0]      ea, eb, ediff;
    logic [FRAC_W-1:0]     fa, fb, frac;
    logic [MW-1:0]         ma, mb_raw, mb, mask, norm;
    logic [MW:0]           sum;
    logic [LZW-1:0]        lz;
    logic signed [EW-1:0]  e_pre, e_fin;
    logic [FRAC_W+1:0]     mant_r;
    logic                  g, rs, up;

    always_comb begin
        // operand order by magnitude; Rm takes the flipped sign
        swap = op_m[W-2:0] > op_n[W-2:0];
        if (swap) begin
            sa = ~op_m[W-1]; ea = op_m[W-2 -: EXP_W]; fa = op_m[FRAC_W-1:0];
            sb =  op_n[W-1]; eb = op_n[W-2 -: EXP_W]; fb = op_n[FRAC_W-1:0];
        end else begin
            sa =  op_n[W-1]; ea = op_n[W-2 -: EXP_W]; fa = op_n[FRAC_W-1:0];
            sb = ~op_m[W-1]; eb = op_m[W-2 -: EXP_W]; fb = op_m[FRAC_W-1:0];
        end
        ediff  = ea - eb;
        ma     = {1'b1, fa, 3'b000};
        mb_raw = {1'b1, fb, 3'b000};
        mask   = '0;
        if (ediff >= EXP_W'(MW)) begin
            mb    = '0;
            mb[0] = 1'b1;
        end else begin
            mb    = mb_raw >> ediff;
            mask  = ~({MW{1'b1}} << ediff);
            mb[0] = mb[0] | (|(mb_raw & mask));
        end

        if (sa ^ sb) sum = {1'b0, ma} - {1'b0, mb};
        else         sum = {1'b0, ma} + {1'b0, mb};

        lz = lead_zeros(sum[MW-1:0]);
        if (sum[MW]) begin
            norm    = sum[MW:1];
            norm[0] = norm[0] | sum[0];
            e_pre   = $signed({2'b00, ea}) + EW'(1);
        end else begin
            norm  = sum[MW-1:0] << lz;
            e_pre = $signed({2'b00, ea}) - $signed({{(EW-LZW){1'b0}}, lz});
        end

        g      = norm[2];
        rs     = norm[1] | norm[0];
        up     = g & (rs | norm[3]);
        mant_r = {1'b0, norm[MW-1:3]} + {{(FRAC_W+1){1'b0}}, up};
        if (mant_r[FRAC_W+1]) begin
            e_fin = e_pre + EW'(1);
            frac  = '0;
        end else begin
            e_fin = e_pre;
            frac  = mant_r[FRAC_W-1:0];
        end

        exc = '0;
        if (sum == '0) begin
            res = '0;
        end else if (e_fin >= E_TOP) begin
            res     = {sa, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
            exc.ovf = 1'b1;
            exc.inx = 1'b1;
        end else if (e_fin <= 0) begin
            res     = {sa, {(W-1){1'b0}}};
            exc.unf = 1'b1;
            exc.inx = 1'b1;
        end else begin
            res     = {sa, e_fin[EXP_W-1:0], frac};
            exc.inx = g | rs;
        end
    end
endmodule

// File: rtl/fsub_select.sv
module fsub_select
    import fsub_pkg::*;
#(
    parameter int EXP_W  = EXP_W_DEF,
    parameter int FRAC_W = FRAC_W_DEF,
    localparam int W     = 1 + EXP_W + FRAC_W
) (
    input  logic [W-1:0] op_n,
    input  logic [W-1:0] op_m,
    input  opclass_e     cls_n,
    input  opclass_e     cls_m,
    input  logic [W-1:0] core_res,
    input  exc_t         core_exc,
    output logic [W-1:0] res,
    output exc_t         exc
);
    localparam logic [W-1:0] DEF_QNAN = {1'b0, {EXP_W{1'b1}}, 1'b0, {(FRAC_W-1){1'b1}}};

    always_comb begin
        exc = '0;
        res = core_res;
        if (cls_n == CL_SNAN || cls_m == CL_SNAN) begin
            exc.invalid = 1'b1;
            res         = DEF_QNAN;
        end else if (cls_n == CL_QNAN || cls_m == CL_QNAN) begin
            res = DEF_QNAN;
        end else if (cls_n == CL_DENORM || cls_m == CL_DENORM) begin
            exc.unimpl = 1'b1;
            res        = op_n;
        end else if (cls_n == CL_INF) begin
            if (cls_m == CL_INF && op_n[W-1] == op_m[W-1]) begin
                exc.invalid = 1'b1;
                res         = DEF_QNAN;
            end else
                res = op_n;
        end else if (cls_m == CL_INF) begin
            res = {~op_m[W-1], op_m[W-2:0]};
        end else if (cls_m == CL_ZERO) begin
            if (cls_n == CL_ZERO) res = {op_n[W-1] & ~op_m[W-1], {(W-1){1'b0}}};
            else                  res = op_n;
        end else if (cls_n == CL_ZERO) begin
            res = {~op_m[W-1], op_m[W-2:0]};
        end else begin
            exc = core_exc;
        end
    end
endmodule

// File: rtl/fp_sub_unit.sv
module fp_sub_unit
    import fsub_pkg::*;
#(
    parameter int EXP_W  = EXP_W_DEF,
    parameter int FRAC_W = FRAC_W_DEF,
    localparam int W     = 1 + EXP_W + FRAC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [W-1:0]      src_n,
    input  logic [W-1:0]      src_m,
    input  logic [FLAG_W-1:0] trap_en,
    input  logic              flag_clr,
    output logic              done,
    output logic [W-1:0]      result,
    output logic              wr_en,
    output logic [EXC_W-1:0]  cause,
    output logic [FLAG_W-1:0] flags,
    output logic              trap_req
);
    localparam logic [W-1:0] DEF_QNAN = {1'b0, {EXP_W{1'b1}}, 1'b0, {(FRAC_W-1){1'b1}}};

    logic [W-1:0] opnd [2];
    opclass_e     cls  [2];
    logic [W-1:0] core_res, sel_res;
    exc_t         core_exc, sel_exc;
    trapen_t      en;
    logic         trap_now;

    assign opnd[0] = src_n;
    assign opnd[1] = src_m;
    assign en      = trapen_t'(trap_en);

    for (genvar k = 0; k < 2; k++) begin : g_cls
        fsub_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
            .val (opnd[k]),
            .cls (cls[k])
        );
    end

    fsub_core #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_core (
        .op_n (src_n),
        .op_m (src_m),
        .res  (core_res),
        .exc  (core_exc)
    );

    fsub_select #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_sel (
        .op_n     (src_n),
        .op_m     (src_m),
        .cls_n    (cls[0]),
        .cls_m    (cls[1]),
        .core_res (core_res),
        .core_exc (core_exc),
        .res      (sel_res),
        .exc      (sel_exc)
    );

    assign trap_now = sel_exc.unimpl | (sel_exc.invalid & en.invalid)
                    | en.ovf | en.unf | en.inx;

    always_ff @(posedge clk) begin
        if (rst) begin
            done     <= 1'b0;
            result   <= '0;
            wr_en    <= 1'b0;
            cause    <= '0;
            flags    <= '0;
            trap_req <= 1'b0;
        end else begin
            done     <= start;
            wr_en    <= start & ~trap_now;
            trap_req <= start & trap_now;
            if (start) begin
                result <= sel_res;
                cause  <= sel_exc;
            end
            flags <= (flag_clr ? '0 : flags) | (start ? exc_to_flag(sel_exc) : '0);
        end
    end

    // R10
    forced_trap_chk: assert property (@(posedge clk) disable iff (rst)
        start && (|trap_en[2:0]) |=> trap_req && !wr_en);

    // R1
    snan_first_chk: assert property (@(posedge clk) disable iff (rst)
        start && (cls[0] == CL_SNAN || cls[1] == CL_SNAN)
        |=> cause[3] && !cause[4] && result == DEF_QNAN);

    // R2
    qnan_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        start && cls[0] != CL_SNAN && cls[1] != CL_SNAN
        && (cls[0] == CL_QNAN || cls[1] == CL_QNAN)
        |=> cause == '0 && result == DEF_QNAN);

    // R3
    denorm_trap_chk: assert property (@(posedge clk) disable iff (rst)
        start && cls[0] != CL_SNAN && cls[1] != CL_SNAN
        && cls[0] != CL_QNAN && cls[1] != CL_QNAN
        && (cls[0] == CL_DENORM || cls[1] == CL_DENORM)
        |=> cause[4] && trap_req && !wr_en && result == $past(src_n));

    // R9
    flags_keep_chk: assert property (@(posedge clk) disable iff (rst)
        !flag_clr |=> ((flags & $past(flags)) == $past(flags)));

    // R11
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !start |=> !done && !wr_en && !trap_req);

endmodule

// File: tb/sim_fp_sub_unit.sv
module sim_fp_sub_unit;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] src_n = '0;
    logic [31:0] src_m = '0;
    logic [3:0]  trap_en = '0;
    logic        flag_clr = 1'b0;
    logic        done, wr_en, trap_req;
    logic [31:0] result;
    logic [4:0]  cause;
    logic [3:0]  flags;

    int ntests = 0;
    int nfail  = 0;
    bit finished = 0;

    localparam logic [31:0] QN = 32'h7FBFFFFF;

    typedef struct {
        logic [31:0] res;
        logic        wr;
        logic [4:0]  cs;
        logic        tr;
        string       req;
    } exp_t;

    exp_t sb[$];

    always #4 clk = ~clk;

    fp_sub_unit u0 (
        .clk(clk), .rst(rst), .start(start), .src_n(src_n), .src_m(src_m),
        .trap_en(trap_en), .flag_clr(flag_clr), .done(done), .result(result),
        .wr_en(wr_en), .cause(cause), .flags(flags), .trap_req(trap_req)
    );

    task automatic send(input logic [31:0] n, input logic [31:0] m, input logic [3:0] en,
                        input logic [31:0] er, input logic ew, input logic [4:0] ec,
                        input logic et, input string req);
        exp_t it;
        @(negedge clk);
        src_n   = n;
        src_m   = m;
        trap_en = en;
        start   = 1'b1;
        it.res = er; it.wr = ew; it.cs = ec; it.tr = et; it.req = req;
        sb.push_back(it);
    endtask

    task automatic idle();
        @(negedge clk);
        start   = 1'b0;
        trap_en = '0;
        @(negedge clk);
    endtask

    task automatic clear_flags();
        @(negedge clk);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
    endtask

    task automatic check_flags(input logic [3:0] ef, input string req);
        ntests++;
        if (flags !== ef) begin
            nfail++;
            $display("FAIL %s flags: actual %b expected %b", req, flags, ef);
        end
    endtask

    task automatic summary();
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && done) begin
            ntests++;
            if (sb.size() == 0) begin
                nfail++;
                $display("FAIL R11 unexpected done: actual done=1 expected done=0");
            end else begin
                exp_t it;
                it = sb.pop_front();
                if (result !== it.res || wr_en !== it.wr || cause !== it.cs || trap_req !== it.tr) begin
                    nfail++;
                    $display("FAIL %s: actual res=%h wr=%b cause=%b trap=%b expected res=%h wr=%b cause=%b trap=%b",
                             it.req, result, wr_en, cause, trap_req, it.res, it.wr, it.cs, it.tr);
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            ntests++;
            nfail++;
            $display("FAIL R11 watchdog: actual hung expected completion");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R8 R9 R11 reset state
        ntests++;
        if (done !== 1'b0 || wr_en !== 1'b0 || trap_req !== 1'b0 || cause !== 5'b0 || result !== 32'h0) begin
            nfail++;
            $display("FAIL R8 reset: actual done=%b wr=%b trap=%b cause=%b res=%h expected all zero",
                     done, wr_en, trap_req, cause, result);
        end
        check_flags(4'b0000, "R9 reset");

        // R4 exact normal differences
        send(32'h40400000, 32'h3F800000, 4'h0, 32'h40000000, 1, 5'b00000, 0, "R4 3-1");
        send(32'h3F800000, 32'h40400000, 4'h0, 32'hC0000000, 1, 5'b00000, 0, "R4 1-3");
        send(32'h3F800000, 32'hBF800000, 4'h0, 32'h40000000, 1, 5'b00000, 0, "R4 1-(-1)");
        send(32'h3F800000, 32'h3F800000, 4'h0, 32'h00000000, 1, 5'b00000, 0, "R4 cancel");
        send(32'h3F800000, 32'h33800000, 4'h0, 32'h3F7FFFFF, 1, 5'b00000, 0, "R4 1-2^-24");
        // R7 zero cases
        send(32'h00000000, 32'h3F800000, 4'h0, 32'hBF800000, 1, 5'b00000, 0, "R7 +0-1");
        send(32'h80000000, 32'hBF800000, 4'h0, 32'h3F800000, 1, 5'b00000, 0, "R7 -0-(-1)");
        send(32'h3F800000, 32'h80000000, 4'h0, 32'h3F800000, 1, 5'b00000, 0, "R7 1-(-0)");
        send(32'h80000000, 32'h00000000, 4'h0, 32'h80000000, 1, 5'b00000, 0, "R7 -0-(+0)");
        send(32'h00000000, 32'h80000000, 4'h0, 32'h00000000, 1, 5'b00000, 0, "R7 +0-(-0)");
        send(32'h80000000, 32'h80000000, 4'h0, 32'h00000000, 1, 5'b00000, 0, "R7 -0-(-0)");
        // R6 infinities
        send(32'h7F800000, 32'h7F800000, 4'h0, QN,           1, 5'b01000, 0, "R6 inf-inf");
        send(32'h7F800000, 32'hFF800000, 4'h0, 32'h7F800000, 1, 5'b00000, 0, "R6 inf-(-inf)");
        send(32'h3F800000, 32'h7F800000, 4'h0, 32'hFF800000, 1, 5'b00000, 0, "R6 1-inf");
        send(32'hFF800000, 32'h3F800000, 4'h0, 32'hFF800000, 1, 5'b00000, 0, "R6 -inf-1");
        idle();
        check_flags(4'b1000, "R9 after inf-inf");
        clear_flags();
        check_flags(4'b0000, "R9 clear");

        // R4 rounding ties
        send(32'h3F800000, 32'hB3800000, 4'h0, 32'h3F800000, 1, 5'b00001, 0, "R4 tie to even down");
        send(32'h3F800001, 32'hB3800000, 4'h0, 32'h3F800002, 1, 5'b00001, 0, "R4 tie to even up");
        idle();
        check_flags(4'b0001, "R9 inexact");
        // R5 overflow / underflow
        send(32'h7F7FFFFF, 32'hFF7FFFFF, 4'h0, 32'h7F800000, 1, 5'b00101, 0, "R5 +overflow");
        send(32'hFF7FFFFF, 32'h7F7FFFFF, 4'h0, 32'hFF800000, 1, 5'b00101, 0, "R5 -overflow");
        send(32'h00C00000, 32'h00800000, 4'h0, 32'h00000000, 1, 5'b00011, 0, "R5 +underflow");
        send(32'h80C00000, 32'h80800000, 4'h0, 32'h80000000, 1, 5'b00011, 0, "R5 -underflow");
        idle();
        check_flags(4'b0111, "R9 accumulate");
        // R1 R2 R3 precedence
        send(32'h7FC00000, 32'h3F800000, 4'h0, QN,           1, 5'b01000, 0, "R1 sNaN n");
        send(32'h7F800001, 32'hFFC00001, 4'h0, QN,           1, 5'b01000, 0, "R1 sNaN m over qNaN");
        send(32'h00000001, 32'h7FC00000, 4'h0, QN,           1, 5'b01000, 0, "R1 sNaN over denorm");
        send(32'h7F800001, 32'h3F800000, 4'h0, QN,           1, 5'b00000, 0, "R2 qNaN");
        send(32'h00000001, 32'hFF800001, 4'h0, QN,           1, 5'b00000, 0, "R2 qNaN over denorm");
        send(32'h00000001, 32'h3F800000, 4'h0, 32'h00000001, 0, 5'b10000, 1, "R3 denorm n");
        send(32'h3F800000, 32'h80000010, 4'h0, 32'h3F800000, 0, 5'b10000, 1, "R3 denorm m");
        idle();
        check_flags(4'b1111, "R9 all");
        clear_flags();

        // R10 trap enables
        send(32'h40400000, 32'h3F800000, 4'b0100, 32'h40000000, 0, 5'b00000, 1, "R10 forced by ovf enable");
        send(32'h40400000, 32'h3F800000, 4'b0001, 32'h40000000, 0, 5'b00000, 1, "R10 forced by inx enable");
        send(32'h40400000, 32'h3F800000, 4'b0010, 32'h40000000, 0, 5'b00000, 1, "R10 forced by unf enable");
        send(32'h40400000, 32'h3F800000, 4'b1000, 32'h40000000, 1, 5'b00000, 0, "R10 invalid enable idle");
        send(32'h7FC00000, 32'h3F800000, 4'b1000, QN,           0, 5'b01000, 1, "R10 invalid enable trap");
        send(32'h7F800001, 32'h3F800000, 4'b0100, QN,           0, 5'b00000, 1, "R10 forced on qNaN");
        send(32'h40400000, 32'h3F800000, 4'b0000, 32'h40000000, 1, 5'b00000, 0, "R8 cause replaced");
        idle();
        check_flags(4'b1000, "R9 after trap ops");
        // R11 quiet when idle
        ntests++;
        if (done !== 1'b0 || wr_en !== 1'b0 || trap_req !== 1'b0 || sb.size() != 0) begin
            nfail++;
            $display("FAIL R11 idle: actual done=%b wr=%b trap=%b pending=%0d expected 0 0 0 0",
                     done, wr_en, trap_req, sb.size());
        end
        summary();
    end

endmodule